// File: doc/BRIEF.md
# Gen-lock Frame Pointer Controller

This block decides which frame-buffer slot a video DMA channel uses for its next frame command, and when that command may start. In master mode it walks through its own ring of buffer slots. It moves to the next slot each time a frame transfer completes, and it publishes the current slot as a Gray-coded pointer so that other channels can follow it.

In slave mode it follows one of several masters instead. All master pointers arrive packed on a single bus. A select value picks one of them. The chosen pointer is passed through a two-flop synchronizer and converted from Gray to binary. That value becomes the slot for a frame at the moment the frame starts.

Transfer starts can run freely: each start follows the previous transfer's completion. They can also be tied to a frame-sync input. In that case the block waits for a full high pulse on that input, a rise followed by a fall, before it raises its start strobe.

Top module: `gl_frame_ptr`

## Requirements
- R1: While `rst` is high at a clock edge, `slot_idx`, `gl_ptr_out` and `xfer_start` all go to 0.
- R2: `xfer_start` is a single-cycle pulse. After a start, no further start occurs until `xfer_done` has been seen high.
- R3: No start occurs while `cfg_enable` is low. With `cfg_use_fsync` low and the block idle, a start occurs on the first clock edge at which `cfg_enable` is high.
- R4: In master mode, every `xfer_done` that ends a transfer advances `slot_idx` by one. After the value `cfg_last_slot` it wraps to 0, and the slot used by the first frame after reset is 0.
- R5: `gl_ptr_out` always equals the Gray code of `slot_idx`, where gray = bin XOR (bin >> 1).
- R6: In slave mode, `slot_idx` at each start is the binary decode of the selected master's Gray pointer. Master i occupies bits [i*PTR_W +: PTR_W] of `gl_ptr_in`, so master 0 sits in the least significant field.
- R7: A `cfg_master_sel` value at or above NUM_MASTERS selects master 0.
- R8: In slave mode, pointer changes that happen after a start do not alter `slot_idx` until the next start.
- R9: With `cfg_use_fsync` high, a start occurs only after a rising edge and then a falling edge of `fsync` have both been seen while idle. A rising edge alone does not start a transfer.
- R10: `fsync` edges seen while a transfer is in progress are discarded. After the transfer ends, a fresh `fsync` pulse is needed.
- R11: `xfer_done` while no transfer is in progress has no effect on `slot_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Permits new transfer starts |
| cfg_slave_mode | input | 1 | 1 follows a master pointer, 0 runs its own slot ring |
| cfg_use_fsync | input | 1 | 1 gates starts on an fsync pulse |
| cfg_last_slot | input | PTR_W | Highest slot index in master mode (buffer count minus one) |
| cfg_master_sel | input | 4 | Index of the master to follow |
| fsync | input | 1 | Frame sync, active high, one pulse per frame |
| xfer_done | input | 1 | Current transfer has finished |
| gl_ptr_in | input | NUM_MASTERS*PTR_W | Packed Gray pointers from the masters |
| gl_ptr_out | output | PTR_W | Gray-coded current slot |
| slot_idx | output | PTR_W | Binary slot for the frame being started |
| xfer_start | output | 1 | One-cycle start strobe |

## Verification
The assertions assume that `xfer_done` arrives only as a pulse ending a transfer and that the configuration inputs stay put while a transfer is in flight. The stimulus changes mode, select and `cfg_last_slot` only while the block is idle and disabled. The assertions also assume `fsync` arrives as a clean pulse at least a few cycles wide. The bench holds each `fsync` level for three or more cycles. After each change to a master pointer it waits more than the synchronizer depth before it enables a start that depends on that pointer.

// File: rtl/gl_pkg.sv
package gl_pkg;

    localparam int GL_MAX_W = 16;
    localparam int GL_SEL_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } gl_state_e;

    typedef struct packed {
        logic enable;
        logic slave_mode;
        logic use_fsync;
    } gl_ctrl_t;

    function automatic logic [GL_MAX_W-1:0] gl_bin2gray(input logic [GL_MAX_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GL_MAX_W-1:0] gl_gray2bin(input logic [GL_MAX_W-1:0] g);
        logic [GL_MAX_W-1:0] b;
        b[GL_MAX_W-1] = g[GL_MAX_W-1];
        for (int i = GL_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/gl_ptr_sync.sv
module gl_ptr_sync
    import gl_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int PTR_W       = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_MASTERS*PTR_W-1:0] ptr_bus_i,
    input  logic [GL_SEL_W-1:0]          sel_i,
    output logic [PTR_W-1:0]             bin_o
);

    logic [PTR_W-1:0] stage1 [NUM_MASTERS];
    logic [PTR_W-1:0] stage2 [NUM_MASTERS];
    logic [PTR_W-1:0] chosen_gray;

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[m] <= '0;
                stage2[m] <= '0;
            end else begin
                stage1[m] <= ptr_bus_i[m*PTR_W +: PTR_W];
                stage2[m] <= stage1[m];
            end
        end
    end

    // Out-of-range selects fall back to master 0
    always_comb begin
        chosen_gray = stage2[0];
        for (int m = 1; m < NUM_MASTERS; m++) begin
            if (int'(sel_i) == m) chosen_gray = stage2[m];
        end
    end

    assign bin_o = PTR_W'(gl_gray2bin(GL_MAX_W'(chosen_gray)));

endmodule

// File: rtl/gl_fsync_edge.sv
module gl_fsync_edge (
    input  logic clk,
    input  logic rst,
    input  logic fsync_i,
    output logic rise_o,
    output logic fall_o
);

    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= fsync_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise_o = s2 & ~s3;
    assign fall_o = ~s2 & s3;

endmodule

// File: rtl/gl_start_fsm.sv
module gl_start_fsm
    import gl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gl_ctrl_t ctrl_i,
    input  logic     fsync_rise_i,
    input  logic     fsync_fall_i,
    input  logic     xfer_done_i,
    output logic     start_fire_o,
    output logic     adv_fire_o,
    output logic     xfer_start_o
);

    gl_state_e state_q, state_d;

    always_comb begin
        start_fire_o = 1'b0;
        if (state_q != ST_BUSY && ctrl_i.enable) begin
            if (!ctrl_i.use_fsync)
                start_fire_o = 1'b1;
            else if (state_q == ST_ARMED && fsync_fall_i)
                start_fire_o = 1'b1;
        end
    end

    assign adv_fire_o = (state_q == ST_BUSY) && xfer_done_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_fire_o)
                    state_d = ST_BUSY;
                else if (ctrl_i.use_fsync && fsync_rise_i)
                    state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (start_fire_o) state_d = ST_BUSY;
            end
            ST_BUSY: begin
                if (xfer_done_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            xfer_start_o <= 1'b0;
        end else begin
            state_q      <= state_d;
            xfer_start_o <= start_fire_o;
        end
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        xfer_start_o |=> !xfer_start_o); // R2

    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        xfer_start_o |-> $past(ctrl_i.enable)); // R3

    AST_FSYNC_GATE: assert property (@(posedge clk) disable iff (rst)
        (xfer_start_o && $past(ctrl_i.use_fsync)) |-> $past(fsync_fall_i)); // R9

endmodule

// File: rtl/gl_frame_ptr.sv
module gl_frame_ptr
    import gl_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int PTR_W       = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_enable,
    input  logic                         cfg_slave_mode,
    input  logic                         cfg_use_fsync,
    input  logic [PTR_W-1:0]             cfg_last_slot,
    input  logic [GL_SEL_W-1:0]          cfg_master_sel,
    input  logic                         fsync,
    input  logic                         xfer_done,
    input  logic [NUM_MASTERS*PTR_W-1:0] gl_ptr_in,
    output logic [PTR_W-1:0]             gl_ptr_out,
    output logic [PTR_W-1:0]             slot_idx,
    output logic                         xfer_start
);

    gl_ctrl_t         ctrl;
    logic             fs_rise, fs_fall;
    logic             start_fire, adv_fire;
    logic [PTR_W-1:0] follow_bin;
    logic [PTR_W-1:0] slot_d;

    assign ctrl = '{enable: cfg_enable, slave_mode: cfg_slave_mode, use_fsync: cfg_use_fsync};

    gl_ptr_sync #(.NUM_MASTERS(NUM_MASTERS), .PTR_W(PTR_W)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ptr_bus_i (gl_ptr_in),
        .sel_i     (cfg_master_sel),
        .bin_o     (follow_bin)
    );

    gl_fsync_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .fsync_i (fsync),
        .rise_o  (fs_rise),
        .fall_o  (fs_fall)
    );

    gl_start_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .ctrl_i       (ctrl),
        .fsync_rise_i (fs_rise),
        .fsync_fall_i (fs_fall),
        .xfer_done_i  (xfer_done),
        .start_fire_o (start_fire),
        .adv_fire_o   (adv_fire),
        .xfer_start_o (xfer_start)
    );

    always_comb begin
        slot_d = slot_idx;
        if (ctrl.slave_mode) begin
            if (start_fire) slot_d = follow_bin;
        end else if (adv_fire) begin
            slot_d = (slot_idx >= cfg_last_slot) ? '0 : slot_idx + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_idx   <= '0;
            gl_ptr_out <= '0;
        end else begin
            slot_idx   <= slot_d;
            gl_ptr_out <= PTR_W'(gl_bin2gray(GL_MAX_W'(slot_d)));
        end
    end

    AST_GRAY_OUT: assert property (@(posedge clk) disable iff (rst)
        gl_ptr_out == PTR_W'(gl_bin2gray(GL_MAX_W'(slot_idx)))); // R5

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start_fire && !adv_fire) |=> $stable(slot_idx)); // R11

endmodule

// File: tb/tb_gl_frame_ptr.sv
module tb_gl_frame_ptr;

    localparam int NM = 4;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_enable, cfg_slave_mode, cfg_use_fsync;
    logic [PW-1:0] cfg_last_slot;
    logic [3:0]    cfg_master_sel;
    logic          fsync, xfer_done;
    logic [NM*PW-1:0] gl_ptr_in;
    logic [PW-1:0] gl_ptr_out, slot_idx;
    logic          xfer_start;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gl_frame_ptr #(.NUM_MASTERS(NM), .PTR_W(PW)) dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_slave_mode(cfg_slave_mode),
        .cfg_use_fsync(cfg_use_fsync), .cfg_last_slot(cfg_last_slot),
        .cfg_master_sel(cfg_master_sel), .fsync(fsync), .xfer_done(xfer_done),
        .gl_ptr_in(gl_ptr_in), .gl_ptr_out(gl_ptr_out), .slot_idx(slot_idx),
        .xfer_start(xfer_start)
    );

    function automatic logic [PW-1:0] gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_start(input int maxc, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (xfer_start) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic count_starts(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (xfer_start) cnt++;
        end
    endtask

    // Ends the current transfer with the block disabled so nothing restarts
    task automatic finish_xfer();
        cfg_enable = 1'b0;
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg_enable = 0; cfg_slave_mode = 0; cfg_use_fsync = 0;
        cfg_last_slot = '0; cfg_master_sel = '0; fsync = 0; xfer_done = 0;
        gl_ptr_in = '0;
        repeat (3) @(negedge clk);
        chk(slot_idx == 0, "R1 slot", int'(slot_idx), 0);
        chk(gl_ptr_out == 0, "R1 gray", int'(gl_ptr_out), 0);
        chk(xfer_start == 0, "R1 start", int'(xfer_start), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_disabled();
        int cnt;
        count_starts(10, cnt);
        chk(cnt == 0, "R3 disabled", cnt, 0);
    endtask

    task automatic t_master_ring();
        bit seen;
        int cnt;
        cfg_last_slot = 4'd2;
        cfg_enable = 1'b1;
        for (int k = 0; k < 7; k++) begin
            wait_start(10, seen);
            chk(seen, "R3 start free-run", int'(seen), 1);
            chk(slot_idx == PW'(k % 3), "R4 slot", int'(slot_idx), k % 3);
            chk(gl_ptr_out == gray(PW'(k % 3)), "R5 gray", int'(gl_ptr_out), int'(gray(PW'(k % 3))));
            count_starts(4, cnt);
            chk(cnt == 0, "R2 single pulse while busy", cnt, 0);
            if (k == 6) begin
                finish_xfer();
            end else begin
                xfer_done = 1'b1;
                @(negedge clk);
                chk(xfer_start == 0, "R2 no start in done cycle", int'(xfer_start), 0);
                xfer_done = 1'b0;
            end
        end
        chk(slot_idx == 1, "R4 wrap count", int'(slot_idx), 1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        repeat (2) @(negedge clk);
        chk(slot_idx == 1, "R11 idle done ignored", int'(slot_idx), 1);
        chk(gl_ptr_out == gray(4'd1), "R5 gray idle", int'(gl_ptr_out), int'(gray(4'd1)));
    endtask

    task automatic slave_once(input logic [3:0] sel, input int exp, input string req);
        bit seen;
        cfg_master_sel = sel;
        repeat (4) @(negedge clk);
        cfg_enable = 1'b1;
        wait_start(6, seen);
        chk(seen, "R3 slave start", int'(seen), 1);
        chk(int'(slot_idx) == exp, req, int'(slot_idx), exp);
        finish_xfer();
    endtask

    task automatic t_slave();
        bit seen;
        cfg_slave_mode = 1'b1;
        gl_ptr_in[0*PW +: PW] = gray(4'd5);
        gl_ptr_in[1*PW +: PW] = gray(4'd9);
        gl_ptr_in[2*PW +: PW] = gray(4'd14);
        gl_ptr_in[3*PW +: PW] = gray(4'd3);
        cfg_master_sel = 4'd2;
        repeat (4) @(negedge clk);
        cfg_enable = 1'b1;
        wait_start(6, seen);
        chk(seen, "R6 start", int'(seen), 1);
        chk(slot_idx == 14, "R6 follow master 2", int'(slot_idx), 14);
        gl_ptr_in[2*PW +: PW] = gray(4'd7);
        repeat (5) @(negedge clk);
        chk(slot_idx == 14, "R8 hold after start", int'(slot_idx), 14);
        finish_xfer();
        chk(slot_idx == 14, "R8 hold after done", int'(slot_idx), 14);
        slave_once(4'd2, 7, "R8 new value at next start");
        slave_once(4'd3, 3, "R6 follow master 3");
        slave_once(4'd0, 5, "R6 follow master 0");
        slave_once(4'd1, 9, "R6 follow master 1");
        slave_once(4'd9, 5, "R7 out of range select");
        slave_once(4'd4, 5, "R7 select equal to count");
        cfg_slave_mode = 1'b0;
    endtask

    task automatic t_fsync();
        bit seen;
        int cnt;
        cfg_use_fsync = 1'b1;
        cfg_enable = 1'b1;
        count_starts(8, cnt);
        chk(cnt == 0, "R9 no start without fsync", cnt, 0);
        fsync = 1'b1;
        count_starts(6, cnt);
        chk(cnt == 0, "R9 rise alone", cnt, 0);
        fsync = 1'b0;
        wait_start(6, seen);
        chk(seen, "R9 start after fall", int'(seen), 1);
        fsync = 1'b1;
        count_starts(3, cnt);
        fsync = 1'b0;
        count_starts(5, cnt);
        chk(cnt == 0, "R10 no start while busy", cnt, 0);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        count_starts(8, cnt);
        chk(cnt == 0, "R10 busy pulse discarded", cnt, 0);
        fsync = 1'b1;
        repeat (3) @(negedge clk);
        fsync = 1'b0;
        wait_start(6, seen);
        chk(seen, "R9 fresh pulse starts", int'(seen), 1);
        finish_xfer();
        cfg_use_fsync = 1'b0;
    endtask

    initial begin
        #2_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_disabled();
        t_master_ring();
        t_slave();
        t_fsync();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule